// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 64 interrupt sources into two 32-bit banks and drives two request lines: a normal request `irq` and a fast request `fiq`. Each source passes through a two-flop synchroniser. It is then treated as a level input with a chosen active polarity, or as an edge input whose detected edge is held in a latch until software clears it. A software trigger bit can force any source pending. A per-source enable gates the source, and a per-source route bit chooses which of the two request lines it feeds.

Software uses a small 32-bit register bus with a single-cycle write strobe and a combinational read port. Every register has a low-bank word and a high-bank word; address bit 2 picks the bank. To find the lowest pending source, software reads the low status word first, then the high one. Enable and soft trigger each have a set register and a separate clear register, so a read-modify-write is never needed.

Top module: `dual_bank_vic`

## Requirements
- R1: After reset, enable, route, soft trigger and all edge latches are zero, and `irq` and `fiq` are low. The level-mode, polarity and both-edge registers read back their parameter reset values.
- R2: The word address is `bus_addr[6:2]`. Bit 2 selects the high bank (sources 32..63) or the low bank (sources 0..31). Bits 6:3 select the register: 0 normal status, 1 fast status, 2 raw pending, 3 route, 4 enable set, 5 enable clear, 6 trigger set, 7 trigger clear, 8 level mode, 9 both-edge, 10 polarity, 11 latch clear, 12 latch status. Indices 13 to 15 read zero. A write to one bank never changes the other bank.
- R3: Writing to index 4 sets every enable bit written as 1, and writing to index 5 clears every enable bit written as 1. Bits written as 0 leave the enable unchanged. Index 4 reads back the enable bits.
- R4: Trigger set (index 6) and trigger clear (index 7) act on the soft-trigger bits with the same set and clear rules as enable. A set trigger bit makes the source pending whatever its input or mode, and index 6 reads back the trigger bits.
- R5: A route bit of 0 sends the source to the normal status and `irq`, and a route bit of 1 sends it to the fast status and `fiq`.
- R6: A level-mode bit of 1 makes the source level sensitive. The source is then pending while its synchronised input equals its polarity bit (1 active high, 0 active low).
- R7: A level-mode bit of 0 makes the source edge sensitive. A polarity bit of 1 latches on a rising edge and 0 latches on a falling edge. The latch stays set until a 1 is written to that bit at index 11. If an edge and the clear arrive in the same cycle, the latch stays set.
- R8: For an edge source with its both-edge bit set, either edge sets the latch and the polarity bit is ignored.
- R9: Level sources never hold a latch: their latch status bits read 0, and a latch-clear write has no effect on their pending state.
- R10: Raw pending is the source's level or latch term ORed with its trigger bit. Normal status is raw AND enable AND NOT route. Fast status is raw AND enable AND route.
- R11: `irq` is the registered OR of all normal status bits of both banks, and `fiq` the registered OR of all fast status bits, each one clock after the status.
- R12: An input change reaches raw pending two clocks later for level sources and sets the latch three clocks later for edge sources. It therefore reaches `irq`/`fiq` three clocks later for level sources and four clocks later for edge sources.
- R13: Writes to the status registers (indices 0, 1, 2, 12) change nothing. The clear-only registers (indices 5, 7, 11) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Asynchronous interrupt source inputs |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 5 | Word address bits 6:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The assertions assume each bus write addresses exactly one register. Because of this, an enable set and an enable clear, or a trigger set and a trigger clear, never land in the same cycle. The assertions also assume that `src_in` is sampled only through the synchroniser. The trigger-to-`irq` assertion further assumes that nothing but the written trigger is pending on the affected path. The bench respects these assumptions because it issues at most one write per cycle and changes sources and bus signals only on the falling clock edge. Its random phase also mixes in writes to unmapped and read-only indices. These writes must be shown to have no effect, so the reference model keeps them inside the same single-write rule.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int IDX_W     = 4;

    typedef logic [BANK_W-1:0] bank_vec_t;

    typedef enum logic [IDX_W-1:0] {
        RG_NRM_ST    = 4'd0,
        RG_FST_ST    = 4'd1,
        RG_RAW       = 4'd2,
        RG_ROUTE     = 4'd3,
        RG_EN_SET    = 4'd4,
        RG_EN_CLR    = 4'd5,
        RG_SW_SET    = 4'd6,
        RG_SW_CLR    = 4'd7,
        RG_LEVEL     = 4'd8,
        RG_BOTH      = 4'd9,
        RG_POL       = 4'd10,
        RG_LATCH_CLR = 4'd11,
        RG_LATCH_ST  = 4'd12
    } reg_idx_e;

    typedef struct packed {
        bank_vec_t en;
        bank_vec_t route;
        bank_vec_t trig;
        bank_vec_t level;
        bank_vec_t pol;
        bank_vec_t both;
        bank_vec_t latch;
        bank_vec_t raw;
        bank_vec_t nrm_st;
        bank_vec_t fst_st;
    } bank_view_t;

    // Edge detection per bit: both-edge wins, else polarity picks rise or fall.
    function automatic bank_vec_t edge_hits(bank_vec_t cur, bank_vec_t prev,
                                            bank_vec_t pol, bank_vec_t both);
        bank_vec_t rise;
        bank_vec_t fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/vic_bank.sv
module vic_bank
    import vic_pkg::*;
#(
    parameter bank_vec_t LEVEL_INIT = '1,
    parameter bank_vec_t POL_INIT   = '1,
    parameter bank_vec_t BOTH_INIT  = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_vec_t  lvl,
    input  logic       wr,
    input  reg_idx_e   idx,
    input  bank_vec_t  wdata,
    output bank_view_t view
);
    bank_vec_t en_q, route_q, trig_q, level_q, pol_q, both_q, latch_q, prev_q;
    bank_vec_t clr_mask, hits, latch_d, raw;

    assign clr_mask = (wr && idx == RG_LATCH_CLR) ? wdata : '0;
    assign hits     = edge_hits(lvl, prev_q, pol_q, both_q);
    // a fresh edge wins over a clear in the same cycle; level sources hold no latch
    assign latch_d  = ((latch_q & ~clr_mask) | hits) & ~level_q;
    assign raw      = (level_q & ~(lvl ^ pol_q)) | (~level_q & latch_q) | trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            trig_q  <= '0;
            latch_q <= '0;
            prev_q  <= '0;
            level_q <= LEVEL_INIT;
            pol_q   <= POL_INIT;
            both_q  <= BOTH_INIT;
        end else begin
            prev_q  <= lvl;
            latch_q <= latch_d;
            if (wr) begin
                case (idx)
                    RG_ROUTE:  route_q <= wdata;
                    RG_EN_SET: en_q    <= en_q | wdata;
                    RG_EN_CLR: en_q    <= en_q & ~wdata;
                    RG_SW_SET: trig_q  <= trig_q | wdata;
                    RG_SW_CLR: trig_q  <= trig_q & ~wdata;
                    RG_LEVEL:  level_q <= wdata;
                    RG_BOTH:   both_q  <= wdata;
                    RG_POL:    pol_q   <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        view.en     = en_q;
        view.route  = route_q;
        view.trig   = trig_q;
        view.level  = level_q;
        view.pol    = pol_q;
        view.both   = both_q;
        view.latch  = latch_q;
        view.raw    = raw;
        view.nrm_st = raw & en_q & ~route_q;
        view.fst_st = raw & en_q & route_q;
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == RG_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == RG_EN_CLR) |=> ((en_q & $past(wdata)) == '0));

    // R4
    trig_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == RG_SW_CLR) |=> ((trig_q & $past(wdata)) == '0));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && idx == RG_LATCH_CLR) |=> (($past(latch_q) & ~$past(level_q) & ~latch_q) == '0));
endmodule

// File: rtl/dual_bank_vic.sv
module dual_bank_vic
    import vic_pkg::*;
#(
    parameter logic [63:0] LEVEL_INIT = 64'hFFFF_FFFF_0000_0000,
    parameter logic [63:0] POL_INIT   = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter logic [63:0] BOTH_INIT  = 64'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] src_in,
    input  logic        bus_wr,
    input  logic [6:2]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        fiq
);
    logic [NUM_SRC-1:0] lvl;
    reg_idx_e           idx;
    logic               bank_sel;
    bank_view_t         view [NUM_BANKS];
    bank_view_t         cur;
    logic               any_nrm, any_fst;

    assign idx      = reg_idx_e'(bus_addr[6:3]);
    assign bank_sel = bus_addr[2];

    vic_sync #(.W(NUM_SRC), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_in),
        .q   (lvl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vic_bank #(
            .LEVEL_INIT (LEVEL_INIT[b*BANK_W +: BANK_W]),
            .POL_INIT   (POL_INIT[b*BANK_W +: BANK_W]),
            .BOTH_INIT  (BOTH_INIT[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .lvl   (lvl[b*BANK_W +: BANK_W]),
            .wr    (bus_wr && (bank_sel == (b != 0))),
            .idx   (idx),
            .wdata (bus_wdata),
            .view  (view[b])
        );
    end

    assign cur = view[bank_sel];

    always_comb begin
        case (idx)
            RG_NRM_ST:   bus_rdata = cur.nrm_st;
            RG_FST_ST:   bus_rdata = cur.fst_st;
            RG_RAW:      bus_rdata = cur.raw;
            RG_ROUTE:    bus_rdata = cur.route;
            RG_EN_SET:   bus_rdata = cur.en;
            RG_SW_SET:   bus_rdata = cur.trig;
            RG_LEVEL:    bus_rdata = cur.level;
            RG_BOTH:     bus_rdata = cur.both;
            RG_POL:      bus_rdata = cur.pol;
            RG_LATCH_ST: bus_rdata = cur.latch;
            default:     bus_rdata = '0;
        endcase
    end

    always_comb begin
        any_nrm = 1'b0;
        any_fst = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            any_nrm = any_nrm | (|view[b].nrm_st);
            any_fst = any_fst | (|view[b].fst_st);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            fiq <= 1'b0;
        end else begin
            irq <= any_nrm;
            fiq <= any_fst;
        end
    end

    // R4
    trig_to_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == RG_SW_SET && ((bus_wdata & cur.en & ~cur.route) != '0))
        |=> ##1 irq);

    // R11
    fiq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (view[0].fst_st == '0 && view[1].fst_st == '0) |=> !fiq);
endmodule

// File: tb/sim_dual_bank_vic.sv
module sim_dual_bank_vic;
    localparam logic [63:0] P_LEVEL = 64'hFFFF_FFFF_0000_0000;
    localparam logic [63:0] P_POL   = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] P_BOTH  = 64'h0;

    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] src_in = '0;
    logic        bus_wr = 0;
    logic [6:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, fiq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    dual_bank_vic u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .fiq(fiq)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    logic [63:0] m_en, m_route, m_trig, m_level, m_pol, m_both, m_latch;
    logic [63:0] m_s1, m_s2, m_prev;
    logic        m_irq, m_fiq;

    function automatic logic [63:0] m_raw();
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            if (m_level[i]) r[i] = (m_s2[i] == m_pol[i]);
            else            r[i] = m_latch[i];
            r[i] = r[i] | m_trig[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [6:2] a);
        logic [63:0] v;
        int idx;
        idx = int'(a[6:3]);
        case (idx)
            0:  v = m_raw() & m_en & ~m_route;
            1:  v = m_raw() & m_en & m_route;
            2:  v = m_raw();
            3:  v = m_route;
            4:  v = m_en;
            6:  v = m_trig;
            8:  v = m_level;
            9:  v = m_both;
            10: v = m_pol;
            12: v = m_latch;
            default: v = '0;
        endcase
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    always @(posedge clk) begin
        logic [63:0] r, w, bm, nl;
        int idx;
        if (rst) begin
            m_en = '0; m_route = '0; m_trig = '0; m_latch = '0;
            m_level = P_LEVEL; m_pol = P_POL; m_both = P_BOTH;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 0; m_fiq = 0;
        end else begin
            r = m_raw();
            bm = bus_addr[2] ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            w  = bus_addr[2] ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
            idx = int'(bus_addr[6:3]);
            for (int i = 0; i < 64; i++) begin
                logic rise, fall, hit, clr;
                rise = m_s2[i] && !m_prev[i];
                fall = !m_s2[i] && m_prev[i];
                if (m_both[i]) hit = rise || fall;
                else if (m_pol[i]) hit = rise;
                else hit = fall;
                clr = bus_wr && idx == 11 && w[i];
                nl[i] = m_level[i] ? 1'b0 : ((m_latch[i] && !clr) || hit);
            end
            if (bus_wr) begin
                case (idx)
                    3:  m_route = (m_route & ~bm) | w;
                    4:  m_en    = m_en | w;
                    5:  m_en    = m_en & ~w;
                    6:  m_trig  = m_trig | w;
                    7:  m_trig  = m_trig & ~w;
                    8:  m_level = (m_level & ~bm) | w;
                    9:  m_both  = (m_both & ~bm) | w;
                    10: m_pol   = (m_pol & ~bm) | w;
                    default: ;
                endcase
            end
            m_irq   = |(r & m_en_before(r));
            m_fiq   = m_fiq_calc;
            m_latch = nl;
            m_prev  = m_s2;
            m_s2    = m_s1;
            m_s1    = src_in;
        end
    end

    // status terms must use state from before this edge: captured each cycle below
    logic [63:0] pre_en, pre_route;
    logic        m_fiq_calc;
    always @(negedge clk) begin
        pre_en    = m_en;
        pre_route = m_route;
        m_fiq_calc = 0;
    end
    function automatic logic [63:0] m_en_before(logic [63:0] r);
        m_fiq_calc = |(r & pre_en & pre_route);
        return pre_en & ~pre_route;
    endfunction

    // ---------------- per-cycle comparison ----------------
    bit cmp_on = 0;
    always @(posedge clk) begin
        #5;
        if (cmp_on && !rst) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL R11 irq act=%0b exp=%0b t=%0t", irq, m_irq, $time);
            end
            total++;
            if (fiq !== m_fiq) begin
                bad++;
                $display("FAIL R11 fiq act=%0b exp=%0b t=%0t", fiq, m_fiq, $time);
            end
            total++;
            if (bus_rdata !== m_read(bus_addr)) begin
                bad++;
                $display("FAIL R2 rdata addr=%0h act=%08h exp=%08h", bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic wr_reg(input int idx, input bit hi, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = {idx[3:0], hi}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input int idx, input bit hi, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = {idx[3:0], hi};
        @(posedge clk); #5;
        total++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s idx=%0d hi=%0b act=%08h exp=%08h", tag, idx, hi, bus_rdata, exp);
        end
    endtask

    task automatic pin_chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<=150000 cycles", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        @(posedge clk); #5;
        // R1 reset state
        pin_chk(irq, 0, "R1 irq");
        pin_chk(fiq, 0, "R1 fiq");
        rd_chk(4, 0, 32'h0, "R1 enable");
        rd_chk(3, 1, 32'h0, "R1 route");
        rd_chk(6, 0, 32'h0, "R1 trig");
        rd_chk(12, 0, 32'h0, "R1 latch");
        rd_chk(8, 0, 32'h0000_0000, "R1 level lo");
        rd_chk(8, 1, 32'hFFFF_FFFF, "R1 level hi");
        rd_chk(10, 0, 32'hFFFF_FFFF, "R1 pol");
        rd_chk(9, 1, 32'h0, "R1 both");

        // R3 enable set / clear
        wr_reg(4, 0, 32'h0000_00F0);
        rd_chk(4, 0, 32'h0000_00F0, "R3 set");
        wr_reg(5, 0, 32'h0000_0030);
        rd_chk(4, 0, 32'h0000_00C0, "R3 clear");
        wr_reg(4, 0, 32'h0);
        rd_chk(4, 0, 32'h0000_00C0, "R3 zero write");
        rd_chk(5, 0, 32'h0, "R13 enable-clear reads zero");

        // R12 / R11 latency for a level source (bit 40 = high bank bit 8)
        wr_reg(4, 1, 32'h0000_0100);
        @(negedge clk); src_in[40] = 1;
        @(posedge clk); #5;
        @(posedge clk); #5; pin_chk(irq, 0, "R12 irq not yet");
        @(posedge clk); #5; pin_chk(irq, 1, "R11 irq after level");
        rd_chk(0, 1, 32'h0000_0100, "R10 normal status hi");
        rd_chk(0, 0, 32'h0, "R2 low bank untouched");

        // R5 route to fast line
        wr_reg(3, 1, 32'h0000_0100);
        wait_cyc(3);
        pin_chk(irq, 0, "R5 irq off");
        pin_chk(fiq, 1, "R5 fiq on");
        rd_chk(1, 1, 32'h0000_0100, "R5 fast status");
        rd_chk(0, 1, 32'h0, "R5 normal status");
        wr_reg(3, 1, 32'h0);
        @(negedge clk); src_in[40] = 0;
        wait_cyc(5);
        pin_chk(irq, 0, "R6 inactive level");

        // R6 active-low polarity
        wr_reg(10, 1, 32'hFFFF_FEFF);
        wait_cyc(4);
        rd_chk(2, 1, 32'h0000_0100, "R6 active low pending");
        @(negedge clk); src_in[40] = 1;
        wait_cyc(4);
        rd_chk(2, 1, 32'h0, "R6 active low idle");
        wr_reg(10, 1, 32'hFFFF_FFFF);

        // R9 latch clear on level source: no effect, latch reads zero
        wr_reg(11, 1, 32'h0000_0100);
        wait_cyc(2);
        rd_chk(2, 1, 32'h0000_0100, "R9 level still pending");
        rd_chk(12, 1, 32'h0, "R9 no latch on level");
        @(negedge clk); src_in[40] = 0;
        wait_cyc(4);

        // R7 rising edge latch (bit 6, low bank edge)
        @(negedge clk); src_in[6] = 1;
        wait_cyc(3);
        @(negedge clk); src_in[6] = 0;
        wait_cyc(5);
        rd_chk(12, 0, 32'h0000_0040, "R7 rise latched");
        pin_chk(irq, 1, "R7 irq from latch");
        wr_reg(11, 0, 32'h0000_0040);
        wait_cyc(2);
        rd_chk(12, 0, 32'h0, "R7 latch cleared");
        pin_chk(irq, 0, "R7 irq dropped");

        // R7 falling edge polarity
        wr_reg(10, 0, 32'hFFFF_FFBF);
        @(negedge clk); src_in[6] = 1;
        wait_cyc(5);
        rd_chk(12, 0, 32'h0, "R7 rise ignored");
        @(negedge clk); src_in[6] = 0;
        wait_cyc(5);
        rd_chk(12, 0, 32'h0000_0040, "R7 fall latched");
        wr_reg(11, 0, 32'h0000_0040);
        wr_reg(10, 0, 32'hFFFF_FFFF);

        // R8 both edges
        wr_reg(9, 0, 32'h0000_0040);
        wr_reg(10, 0, 32'hFFFF_FFBF);
        @(negedge clk); src_in[6] = 1;
        wait_cyc(5);
        rd_chk(12, 0, 32'h0000_0040, "R8 rise latched");
        wr_reg(11, 0, 32'h0000_0040);
        wait_cyc(2);
        @(negedge clk); src_in[6] = 0;
        wait_cyc(5);
        rd_chk(12, 0, 32'h0000_0040, "R8 fall latched");
        wr_reg(11, 0, 32'h0000_0040);
        wr_reg(9, 0, 32'h0);
        wr_reg(10, 0, 32'hFFFF_FFFF);
        wait_cyc(2);

        // R4 soft trigger
        wr_reg(6, 0, 32'h0000_0081);
        wait_cyc(2);
        pin_chk(irq, 1, "R4 trigger irq");
        rd_chk(6, 0, 32'h0000_0081, "R4 trigger readback");
        rd_chk(0, 0, 32'h0000_0080, "R10 disabled bit masked");
        rd_chk(2, 0, 32'h0000_0081, "R10 raw includes trigger");
        wr_reg(7, 0, 32'h0000_0081);
        wait_cyc(2);
        rd_chk(6, 0, 32'h0, "R4 trigger cleared");
        pin_chk(irq, 0, "R4 irq off");
        rd_chk(7, 0, 32'h0, "R13 trigger-clear reads zero");

        // R13 writes to status registers ignored
        wr_reg(0, 0, 32'hFFFF_FFFF);
        wr_reg(12, 0, 32'hFFFF_FFFF);
        wr_reg(2, 1, 32'hFFFF_FFFF);
        rd_chk(4, 0, 32'h0000_00C0, "R13 enable unchanged");
        rd_chk(12, 0, 32'h0, "R13 latch unchanged");
        rd_chk(3, 0, 32'h0, "R13 route unchanged");
        rd_chk(11, 0, 32'h0, "R13 latch-clear reads zero");

        // R2 bank separation
        wr_reg(4, 1, 32'h0000_0001);
        rd_chk(4, 1, 32'h0000_0101, "R2 high enable");
        rd_chk(4, 0, 32'h0000_00C0, "R2 low enable");

        // random phase, compared every cycle against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) src_in[$urandom % 64] = ~src_in[$urandom % 64];
            if (($urandom % 8) == 0) src_in = {$urandom, $urandom};
            bus_addr = 5'($urandom);
            bus_wdata = $urandom;
            bus_wr = (($urandom % 3) == 0);
        end
        @(negedge clk);
        bus_wr = 0;
        wait_cyc(4);
        finish_run();
    end
endmodule